// File: doc/BRIEF.md
# PCM Audio Serial Transmitter

This block sends PCM audio samples to an external codec, one bit per shift-clock period, most significant bit first. It also drives a frame sync line. The shift clock comes from outside as a one-cycle enable, `bit_en`, in the system clock domain. Each enabled clock edge starts a new bit period, and every output register changes only on such an edge. The upstream side offers a parallel sample together with its frame configuration through a valid/ready handshake. The block captures both at the start of the frame, so the inputs may change while the frame is being sent.

A frame has three parts. The first is a lead period, in which the sync line is active and the data line is low. Then come the slot bits, 8 or 16 of them. Last comes a return to idle, in which sync is inactive and data is low. Short sync mode holds sync active only for the lead period. Long sync mode holds it active for a fixed number of periods counted from the lead period: 6 periods in 8-bit mode, and 13 to 16 periods in 16-bit mode. In 16-bit mode, up to three codec control bits can replace the tail of the slot. A polarity input inverts the sync line for codecs that expect an active-low sync.

The FSM has four states:
- `ST_IDLE` accepts a sample (transition *accept*).
- `ST_ARMED` waits for the next bit period (transition *launch*).
- `ST_LEAD` is the sync-only lead period, followed by transition *first bit*.
- `ST_SHIFT` sends slot bits (transition *next bit*) until the slot is finished (transition *finish*, back to `ST_IDLE`).

Top module: `pcm_tx`

## Requirements
- R1: During and after reset, `smp_ready` is 1, `sd_o` is 0 and `fs_o` is 0 (with `cfg_fs_inv` at 0).
- R2: A sample is accepted on a clock edge where `smp_valid` and `smp_ready` are both 1. From the next cycle, `smp_ready` stays 0 until the frame has finished, and sample and configuration inputs changed after acceptance do not affect the frame.
- R3: With `cfg_long_fs`=0, sync is active for exactly one bit period, the lead period, which directly precedes the first slot bit.
- R4: With `cfg_long_fs`=1 and `cfg_wide`=0, sync is active for 6 bit periods, starting with the lead period.
- R5: With `cfg_long_fs`=1 and `cfg_wide`=1, sync is active for 13 + `cfg_long_len` bit periods (`cfg_long_len` 0..3 gives 13..16), starting with the lead period.
- R6: With `cfg_wide`=0, the slot is 8 bits, sending `smp_data[7]` down to `smp_data[0]`.
- R7: With `cfg_wide`=1 and `cfg_ctl_cnt`=0, the slot is 16 bits, sending `smp_data[15]` down to `smp_data[0]`.
- R8: With `cfg_wide`=1 and `cfg_ctl_cnt`=n (1..3), the slot sends `smp_data[15]` down to `smp_data[n]`, followed by `cfg_ctl_bits[0]`, then `[1]`, then `[2]`, up to n control bits, which fill the 16-bit slot. `cfg_ctl_cnt` has no effect in 8-bit mode.
- R9: `fs_o` equals the internal sync-active level XOR `cfg_fs_inv`, where `cfg_fs_inv` is taken through one register stage.
- R10: `sd_o` is 0 in the lead period and whenever the block is idle. In the period after the last slot bit, sync is inactive and `smp_ready` returns to 1, so at least one sync-inactive period separates frames.
- R11: On a clock edge with `bit_en`=0, `fs_o` and `sd_o` keep their values (apart from a polarity change under R9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe starting a shift-clock bit period |
| smp_valid | input | 1 | Sample and configuration offered |
| smp_ready | output | 1 | Block idle and able to take a sample |
| smp_data | input | 16 | PCM sample, left-justified in 16-bit mode |
| cfg_wide | input | 1 | 1: 16-bit slot, 0: 8-bit slot |
| cfg_long_fs | input | 1 | 1: long sync pulse, 0: one-period sync |
| cfg_long_len | input | 2 | Long sync length select in 16-bit mode (13 + value) |
| cfg_ctl_cnt | input | 2 | Number of control bits appended in 16-bit mode |
| cfg_ctl_bits | input | 3 | Control bit values, bit 0 sent first |
| cfg_fs_inv | input | 1 | Invert the frame sync output |
| fs_o | output | 1 | Frame sync line |
| sd_o | output | 1 | Serial data line |

## Verification
A wrong bit counter or a slot-length mix-up shows on `sd_o` inside the frame where it occurs. It usually also moves the return of `smp_ready` by whole bit periods, so the same frame shows it. A wrong sync-length decode shows as an early or late fall of `fs_o` within the first 16 bit periods of the frame. A broken bit-enable gate shows as outputs that change between enables. Frames are captured at every bit period and compared with a model built from the requirements. Strobe densities are mixed, so both the sequencing and the gating between strobes are exposed.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int unsigned CTL_W     = 3;
    localparam int unsigned LEN_SEL_W = 2;
    localparam int unsigned CNT_SEL_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LEAD,
        ST_SHIFT
    } tx_state_e;

    typedef struct packed {
        logic                 wide;
        logic                 long_fs;
        logic [LEN_SEL_W-1:0] len_sel;
        logic [CNT_SEL_W-1:0] ctl_cnt;
        logic [CTL_W-1:0]     ctl_bits;
    } frame_cfg_t;

endpackage

// File: rtl/pcm_tx_len.sv
// Derives the sync pulse length and the slot length, in bit periods,
// from the frame configuration captured at the start of the frame.
module pcm_tx_len
    import pcm_tx_pkg::*;
#(
    parameter int unsigned SLOT_W        = 16,
    parameter int unsigned NARROW_W      = 8,
    parameter int unsigned NARROW_SYNC   = 6,
    parameter int unsigned LONG_SYNC_MIN = 13,
    localparam int unsigned CW           = $clog2(SLOT_W + 2)
) (
    input  frame_cfg_t    cfg,
    output logic [CW-1:0] sync_len,
    output logic [CW-1:0] slot_len
);

    localparam logic [CW-1:0] LEN_ONE    = CW'(1);
    localparam logic [CW-1:0] LEN_NARROW = CW'(NARROW_SYNC);
    localparam logic [CW-1:0] LEN_BASE   = CW'(LONG_SYNC_MIN);
    localparam logic [CW-1:0] SLOT_WIDE  = CW'(SLOT_W);
    localparam logic [CW-1:0] SLOT_NARR  = CW'(NARROW_W);

    always_comb begin
        if (!cfg.long_fs) begin
            sync_len = LEN_ONE;
        end else if (cfg.wide) begin
            sync_len = LEN_BASE + CW'(cfg.len_sel);
        end else begin
            sync_len = LEN_NARROW;
        end
        slot_len = cfg.wide ? SLOT_WIDE : SLOT_NARR;
    end

endmodule

// File: rtl/pcm_tx_slot.sv
// Builds the slot in transmit order (index 0 goes out first) and picks
// the bit for the requested index.
module pcm_tx_slot
    import pcm_tx_pkg::*;
#(
    parameter int unsigned SLOT_W   = 16,
    parameter int unsigned NARROW_W = 8,
    localparam int unsigned CW      = $clog2(SLOT_W + 2),
    localparam int unsigned WIW     = $clog2(SLOT_W),
    localparam int unsigned NIW     = $clog2(NARROW_W)
) (
    input  logic [SLOT_W-1:0] sample,
    input  frame_cfg_t        cfg,
    input  logic [CW-1:0]     idx,
    output logic              bit_o
);

    logic [SLOT_W-1:0]   wide_slot;
    logic [NARROW_W-1:0] narrow_slot;

    // Wide slot: the PCM bits come first, then the control bits fill the tail.
    for (genvar i = 0; i < SLOT_W; i++) begin : g_wide
        localparam int unsigned FROM_END = SLOT_W - 1 - i;
        always_comb begin
            int ctl_pos;
            ctl_pos = int'(cfg.ctl_cnt) - 1 - int'(FROM_END);
            if (int'(cfg.ctl_cnt) > int'(FROM_END) && ctl_pos < int'(CTL_W)) begin
                wide_slot[i] = cfg.ctl_bits[ctl_pos[$clog2(CTL_W)-1:0]];
            end else begin
                wide_slot[i] = sample[SLOT_W-1-i];
            end
        end
    end

    // Narrow slot: the low bits of the sample, MSB first.
    for (genvar j = 0; j < NARROW_W; j++) begin : g_narrow
        assign narrow_slot[j] = sample[NARROW_W-1-j];
    end

    always_comb begin
        bit_o = 1'b0;
        if (cfg.wide) begin
            if (idx < CW'(SLOT_W)) begin
                bit_o = wide_slot[idx[WIW-1:0]];
            end
        end else begin
            if (idx < CW'(NARROW_W)) begin
                bit_o = narrow_slot[idx[NIW-1:0]];
            end
        end
    end

endmodule

// File: rtl/pcm_tx_fsm.sv
// Frame sequencer: a state register, a next-state decoder and an output
// process that updates the line registers once per bit period.
module pcm_tx_fsm
    import pcm_tx_pkg::*;
#(
    parameter int unsigned SLOT_W = 16,
    localparam int unsigned CW    = $clog2(SLOT_W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          smp_valid,
    input  logic [CW-1:0] sync_len,
    input  logic [CW-1:0] slot_len,
    input  logic          slot_bit,
    output tx_state_e     state_o,
    output logic [CW-1:0] pcnt_o,
    output logic          load_o,
    output logic          fs_act_o,
    output logic          sd_o
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    tx_state_e     state_q, state_d;
    logic [CW-1:0] pcnt_q;
    logic [CW-1:0] pcnt_inc;
    logic          slot_done;

    assign pcnt_inc  = pcnt_q + CNT_ONE;
    assign slot_done = (pcnt_q == slot_len);
    assign load_o    = (state_q == ST_IDLE) && smp_valid;

    // Next-state decoder
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (smp_valid) state_d = ST_ARMED;               // accept
            ST_ARMED: if (bit_en)    state_d = ST_LEAD;                // launch
            ST_LEAD:  if (bit_en)    state_d = ST_SHIFT;               // first bit
            ST_SHIFT: if (bit_en)    state_d = slot_done ? ST_IDLE      // finish
                                                         : ST_SHIFT;    // next bit
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: line registers and the bit-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q   <= '0;
            fs_act_o <= 1'b0;
            sd_o     <= 1'b0;
        end else if (bit_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    fs_act_o <= 1'b0;
                    sd_o     <= 1'b0;
                end
                ST_ARMED: begin
                    pcnt_q   <= '0;
                    fs_act_o <= 1'b1;
                    sd_o     <= 1'b0;
                end
                ST_LEAD, ST_SHIFT: begin
                    if (slot_done) begin
                        pcnt_q   <= '0;
                        fs_act_o <= 1'b0;
                        sd_o     <= 1'b0;
                    end else begin
                        pcnt_q   <= pcnt_inc;
                        fs_act_o <= (pcnt_inc < sync_len);
                        sd_o     <= slot_bit;
                    end
                end
                default: begin
                    fs_act_o <= 1'b0;
                    sd_o     <= 1'b0;
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign pcnt_o  = pcnt_q;

endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
    import pcm_tx_pkg::*;
#(
    parameter int unsigned SLOT_W        = 16,
    parameter int unsigned NARROW_W      = 8,
    parameter int unsigned NARROW_SYNC   = 6,
    parameter int unsigned LONG_SYNC_MIN = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 smp_valid,
    output logic                 smp_ready,
    input  logic [SLOT_W-1:0]    smp_data,
    input  logic                 cfg_wide,
    input  logic                 cfg_long_fs,
    input  logic [LEN_SEL_W-1:0] cfg_long_len,
    input  logic [CNT_SEL_W-1:0] cfg_ctl_cnt,
    input  logic [CTL_W-1:0]     cfg_ctl_bits,
    input  logic                 cfg_fs_inv,
    output logic                 fs_o,
    output logic                 sd_o
);

    localparam int unsigned CW = $clog2(SLOT_W + 2);

    frame_cfg_t        cfg_q;
    logic [SLOT_W-1:0] smp_q;
    logic              inv_q;
    logic              load;
    logic              fs_act;
    logic              slot_bit;
    logic [CW-1:0]     sync_len;
    logic [CW-1:0]     slot_len;
    logic [CW-1:0]     pcnt;
    tx_state_e         state;

    // Sample and configuration are captured when the frame is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            smp_q <= '0;
        end else if (load) begin
            cfg_q.wide     <= cfg_wide;
            cfg_q.long_fs  <= cfg_long_fs;
            cfg_q.len_sel  <= cfg_long_len;
            cfg_q.ctl_cnt  <= cfg_ctl_cnt;
            cfg_q.ctl_bits <= cfg_ctl_bits;
            smp_q          <= smp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
        end else begin
            inv_q <= cfg_fs_inv;
        end
    end

    pcm_tx_len #(
        .SLOT_W       (SLOT_W),
        .NARROW_W     (NARROW_W),
        .NARROW_SYNC  (NARROW_SYNC),
        .LONG_SYNC_MIN(LONG_SYNC_MIN)
    ) u_len (
        .cfg      (cfg_q),
        .sync_len (sync_len),
        .slot_len (slot_len)
    );

    pcm_tx_slot #(
        .SLOT_W   (SLOT_W),
        .NARROW_W (NARROW_W)
    ) u_slot (
        .sample (smp_q),
        .cfg    (cfg_q),
        .idx    (pcnt),
        .bit_o  (slot_bit)
    );

    pcm_tx_fsm #(
        .SLOT_W (SLOT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .smp_valid (smp_valid),
        .sync_len  (sync_len),
        .slot_len  (slot_len),
        .slot_bit  (slot_bit),
        .state_o   (state),
        .pcnt_o    (pcnt),
        .load_o    (load),
        .fs_act_o  (fs_act),
        .sd_o      (sd_o)
    );

    assign smp_ready = (state == ST_IDLE);
    assign fs_o      = fs_act ^ inv_q;

endmodule

// File: rtl/pcm_tx_chk.sv
module pcm_tx_chk #(
    parameter int unsigned SLOT_W = 16,
    localparam int unsigned RW    = $clog2(SLOT_W + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic cfg_fs_inv,
    input logic smp_valid,
    input logic smp_ready,
    input logic fs_o,
    input logic sd_o,
    input logic inv_q
);

    logic [RW-1:0] sync_run;
    logic          sync_active;

    assign sync_active = fs_o ^ inv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_run <= '0;
        end else if (bit_en) begin
            if (sync_active && sync_run < RW'(SLOT_W + 1)) begin
                sync_run <= sync_run + RW'(1);
            end else if (!sync_active) begin
                sync_run <= '0;
            end
        end
    end

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_en) && ($past(cfg_fs_inv) == $past(cfg_fs_inv, 2)))
            |-> ($stable(fs_o) && $stable(sd_o))); // R11

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready); // R2

    AST_IDLE_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> (!sd_o && (fs_o == inv_q))); // R10

    AST_SYNC_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sync_run <= RW'(SLOT_W)); // R5

    AST_POLARITY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && $past(smp_ready) && $past(smp_ready, 2)) |-> (fs_o == $past(cfg_fs_inv))); // R9

endmodule

bind pcm_tx pcm_tx_chk #(.SLOT_W(SLOT_W)) u_pcm_tx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .cfg_fs_inv (cfg_fs_inv),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .fs_o       (fs_o),
    .sd_o       (sd_o),
    .inv_q      (inv_q)
);

// File: tb/test_pcm_tx.sv
`timescale 1ns/1ps
module test_pcm_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [15:0] smp_data = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_long_fs = 1'b0;
    logic [1:0]  cfg_long_len = '0;
    logic [1:0]  cfg_ctl_cnt = '0;
    logic [2:0]  cfg_ctl_bits = '0;
    logic        cfg_fs_inv = 1'b0;
    logic        fs_o;
    logic        sd_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    pcm_tx i_pcm_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .smp_valid    (smp_valid),
        .smp_ready    (smp_ready),
        .smp_data     (smp_data),
        .cfg_wide     (cfg_wide),
        .cfg_long_fs  (cfg_long_fs),
        .cfg_long_len (cfg_long_len),
        .cfg_ctl_cnt  (cfg_ctl_cnt),
        .cfg_ctl_bits (cfg_ctl_bits),
        .cfg_fs_inv   (cfg_fs_inv),
        .fs_o         (fs_o),
        .sd_o         (sd_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected slot bit at transmit position i (R6, R7, R8)
    function automatic bit exp_slot_bit(bit wide, bit [1:0] n, bit [2:0] ctl, bit [15:0] d, int i);
        if (!wide) return d[7 - i];
        if (i < 16 - int'(n)) return d[15 - i];
        return ctl[i - (16 - int'(n))];
    endfunction

    function automatic int exp_sync_len(bit wide, bit lng, bit [1:0] lsel);
        if (!lng) return 1;
        if (wide) return 13 + int'(lsel);
        return 6;
    endfunction

    task automatic run_frame(input bit wide, input bit lng, input bit [1:0] lsel,
                             input bit [1:0] n, input bit [2:0] ctl, input bit inv,
                             input bit [15:0] d, input int dens);
        int          w;
        int          sl;
        int          k;
        bit          held_ok;
        bit          rdy_end;
        logic        last_fs;
        logic        last_sd;
        logic [17:0] a_fs;
        logic [17:0] a_sd;
        logic [17:0] e_fs;
        logic [17:0] e_sd;
        string       fs_req;
        string       sd_req;

        w  = wide ? 16 : 8;
        sl = exp_sync_len(wide, lng, lsel);
        a_fs = '0; a_sd = '0; e_fs = '0; e_sd = '0;

        bit_en     = 1'b0;
        cfg_fs_inv = inv;
        @(negedge clk);
        @(negedge clk);
        check(fs_o == inv, "R9 idle polarity", {31'd0, fs_o}, {31'd0, inv});

        smp_valid    = 1'b1;
        smp_data     = d;
        cfg_wide     = wide;
        cfg_long_fs  = lng;
        cfg_long_len = lsel;
        cfg_ctl_cnt  = n;
        cfg_ctl_bits = ctl;
        @(negedge clk);
        smp_valid = 1'b0;
        check(smp_ready == 1'b0, "R2 ready drops after accept", {31'd0, smp_ready}, 32'd0);
        // Scramble inputs: the frame must use captured values (R2)
        smp_data     = 16'($urandom);
        cfg_ctl_bits = 3'($urandom);
        cfg_ctl_cnt  = 2'($urandom);
        cfg_long_len = 2'($urandom);

        last_fs = fs_o;
        last_sd = sd_o;
        held_ok = 1'b1;
        rdy_end = 1'b0;
        k = 0;
        while (k < w + 2) begin
            bit en;
            en = (($urandom % 4) < dens);
            bit_en = en;
            @(negedge clk);
            if (en) begin
                a_fs[k] = fs_o;
                a_sd[k] = sd_o;
                if (k == w + 1) rdy_end = smp_ready;
                k++;
            end else if (fs_o !== last_fs || sd_o !== last_sd) begin
                held_ok = 1'b0;
            end
            last_fs = fs_o;
            last_sd = sd_o;
        end
        bit_en = 1'b0;

        for (int p = 0; p < w + 2; p++) begin
            e_fs[p] = (p < sl) ^ inv;
            e_sd[p] = (p >= 1 && p <= w) ? exp_slot_bit(wide, n, ctl, d, p - 1) : 1'b0;
        end

        if (!lng)      fs_req = inv ? "R3 R9 short sync" : "R3 short sync";
        else if (wide) fs_req = inv ? "R5 R9 long wide sync" : "R5 long wide sync";
        else           fs_req = inv ? "R4 R9 long narrow sync" : "R4 long narrow sync";
        if (!wide)       sd_req = "R6 narrow slot data";
        else if (n == 0) sd_req = "R7 wide slot data";
        else             sd_req = "R8 wide slot with control bits";

        check(a_fs == e_fs, fs_req, {14'd0, a_fs}, {14'd0, e_fs});
        check(a_sd == e_sd, sd_req, {14'd0, a_sd}, {14'd0, e_sd});
        check(held_ok, "R11 outputs hold between strobes", {31'd0, held_ok}, 32'd1);
        check(rdy_end && (a_fs[w + 1] == inv) && !a_sd[w + 1] && !a_sd[0],
              "R10 lead and end periods", {29'd0, rdy_end, a_fs[w + 1], a_sd[w + 1]},
              {29'd0, 1'b1, inv, 1'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(smp_ready == 1'b1 && sd_o == 1'b0 && fs_o == 1'b0, "R1 in reset",
              {29'd0, smp_ready, sd_o, fs_o}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(smp_ready == 1'b1 && sd_o == 1'b0 && fs_o == 1'b0, "R1 after reset",
              {29'd0, smp_ready, sd_o, fs_o}, 32'h4);

        // Directed corner cases
        run_frame(1'b0, 1'b0, 2'd0, 2'd0, 3'b000, 1'b0, 16'h00A5, 4); // short, narrow
        run_frame(1'b0, 1'b1, 2'd3, 2'd3, 3'b111, 1'b0, 16'hFF3C, 4); // long narrow, ctl ignored
        run_frame(1'b1, 1'b1, 2'd0, 2'd0, 3'b000, 1'b0, 16'hBEEF, 4); // 13
        run_frame(1'b1, 1'b1, 2'd1, 2'd0, 3'b000, 1'b0, 16'h1234, 4); // 14
        run_frame(1'b1, 1'b1, 2'd2, 2'd0, 3'b000, 1'b0, 16'h8001, 4); // 15
        run_frame(1'b1, 1'b1, 2'd3, 2'd0, 3'b000, 1'b0, 16'h7FFE, 4); // 16
        run_frame(1'b1, 1'b0, 2'd0, 2'd1, 3'b001, 1'b0, 16'h0000, 4); // one ctl bit
        run_frame(1'b1, 1'b0, 2'd0, 2'd2, 3'b010, 1'b0, 16'hFFFF, 4); // two ctl bits
        run_frame(1'b1, 1'b1, 2'd0, 2'd3, 3'b001, 1'b0, 16'hFFF8, 4); // 13 PCM + 3 ctl
        run_frame(1'b1, 1'b1, 2'd3, 2'd3, 3'b110, 1'b1, 16'hA5A5, 2); // inverted, sparse strobes
        run_frame(1'b0, 1'b0, 2'd0, 2'd0, 3'b000, 1'b1, 16'h005A, 1); // inverted short, sparse

        // Constrained random frames
        for (int f = 0; f < 48; f++) begin
            run_frame(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
                      3'($urandom), 1'($urandom), 16'($urandom), 1 + int'($urandom % 4));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule